// File: doc/BRIEF.md
# Split-Write Channel Value Buffer

A 16-bit channel value that software reaches over an 8-bit bus must be written as two bytes. This block holds those bytes in a shadow word until both have arrived, in either order. Only then does it hand the full word to the live channel value. A compare stage never sees half of an old value joined to half of a new one.

When the timer runs a PWM mode with a clock source selected, the complete word waits for the end of the counting period. It is loaded on the clock edge where the counter moves from the period limit minus one to the limit. A modulo setting of zero means the counter runs freely, so the limit is 0xFFFF. In any other case the word is loaded on the same edge that accepts its second byte.

A write to the channel control register clears a half-finished pair. While a debugger holds the chip, byte writes go straight into the live value and leave the shadow word and its pairing flags exactly as they were. A sequence that was begun before the halt can therefore be finished afterwards with the bytes that were buffered before it.

Top module: `chan_pair_buf`

## Requirements
- R1: After reset, `chan_val` is 0x0000 and neither byte is marked as written.
- R2: With `pwm_mode` = 0, a low-byte write (`wr_hi` = 0, data into bits 7:0) followed by a high-byte write (`wr_hi` = 1, data into bits 15:8), or the same two in the reverse order, loads the combined word into `chan_val` on the clock edge that accepts the second byte.
- R3: A single byte write, or repeated writes to the same half, leaves `chan_val` unchanged. The last byte written to a half is the one used when the pair completes.
- R4: With `pwm_mode` = 1 and `clk_sel` = 0 (no clock), a completed pair loads at once, as in R2.
- R5: With `pwm_mode` = 1 and `clk_sel` != 0, a completed word stays pending. It loads on the edge where `cnt` steps from `modulo`-1 to `modulo`, and on no other counter step.
- R6: When `modulo` = 0 in the R5 setting, the pending word loads on the step from 0xFFFE to 0xFFFF, and a step into any other value does not load it.
- R7: A `ctl_wr` pulse clears a half-finished pair, so both bytes must be written again before a load. This holds with `dbg_active` set as well.
- R8: With `dbg_active` = 1, a byte write goes straight into its half of `chan_val` on the next edge. The shadow bytes and the pairing flags keep their values.
- R9: Values written during debug stay in `chan_val` after `dbg_active` returns to 0.
- R10: A pair begun before debug and completed after it loads the byte buffered before debug, not the byte written during debug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe for the channel value |
| wr_hi | input | 1 | 1 selects the high byte, 0 selects the low byte |
| wr_data | input | 8 | Byte being written |
| ctl_wr | input | 1 | Write strobe for the channel control register; clears pairing |
| dbg_active | input | 1 | Debug halt in progress |
| cnt | input | 16 | Current timer counter value |
| modulo | input | 16 | Period limit; 0 selects a free-running counter |
| clk_sel | input | 2 | Timer clock select; 0 means no clock |
| pwm_mode | input | 1 | Edge- or center-aligned PWM is active |
| chan_val | output | 16 | Live channel value |

## Verification
In immediate mode and in debug mode, `chan_val` changes on the first rising edge after the strobe is presented. The bench drives every input on a falling edge and reads `chan_val` on the falling edge that follows, so a single clock separates stimulus and check. In PWM mode the load follows a counter step. The bench sets `cnt` one value per clock, and the counter's previous value is registered inside the block. The check after the step into the limit therefore reads the new word, while the check after the preceding step still reads the old one.

// File: rtl/cpb_pkg.sv
`timescale 1ns/1ps
package cpb_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } seen_t;

  localparam seen_t SEEN_NONE = '{hi: 1'b0, lo: 1'b0};
endpackage

// File: rtl/cpb_pair_track.sv
`timescale 1ns/1ps
module cpb_pair_track
  import cpb_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_hi,
  input  logic [HALF_W-1:0]     wr_data,
  input  logic                  clr,
  input  logic                  freeze,
  output seen_t                 seen,
  output logic [2*HALF_W-1:0]   word_nxt,
  output logic                  complete
);
  localparam int unsigned WORD_W = 2 * HALF_W;

  logic              take;
  seen_t             seen_after;
  seen_t             seen_d;
  logic              seen_en;
  logic [WORD_W-1:0] shadow_q;
  logic [WORD_W-1:0] shadow_d;
  logic [1:0]        half_sel;

  assign take     = wr_en && !freeze;
  assign half_sel = {take && wr_hi, take && !wr_hi};

  // Shadow byte update: one generate arm per half.
  for (genvar g = 0; g < 2; g++) begin : g_half
    assign shadow_d[g*HALF_W +: HALF_W] =
      half_sel[g] ? wr_data : shadow_q[g*HALF_W +: HALF_W];
  end

  always_comb begin
    seen_after.hi = seen.hi | (take && !clr && wr_hi);
    seen_after.lo = seen.lo | (take && !clr && !wr_hi);
    complete      = seen_after.hi && seen_after.lo && !clr;
    if (clr || complete) begin
      seen_d = SEEN_NONE;
    end else begin
      seen_d = seen_after;
    end
    seen_en  = clr || !freeze;
    word_nxt = shadow_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= SEEN_NONE;
      shadow_q <= '0;
    end else begin
      if (seen_en) begin
        seen <= seen_d;
      end
      if (take) begin
        shadow_q <= shadow_d;
      end
    end
  end
endmodule

// File: rtl/cpb_wrap_detect.sv
`timescale 1ns/1ps
module cpb_wrap_detect #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] modulo,
  output logic             at_wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] limit_m1;

  always_comb begin
    limit    = (modulo == '0) ? '1 : modulo;
    limit_m1 = limit - 1'b1;
    at_wrap  = (cnt_q == limit_m1) && (cnt == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt;
    end
  end
endmodule

// File: rtl/chan_pair_buf.sv
`timescale 1ns/1ps
module chan_pair_buf
  import cpb_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned CS_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_hi,
  input  logic [HALF_W-1:0]     wr_data,
  input  logic                  ctl_wr,
  input  logic                  dbg_active,
  input  logic [2*HALF_W-1:0]   cnt,
  input  logic [2*HALF_W-1:0]   modulo,
  input  logic [CS_W-1:0]       clk_sel,
  input  logic                  pwm_mode,
  output logic [2*HALF_W-1:0]   chan_val
);
  localparam int unsigned WORD_W = 2 * HALF_W;

  seen_t             seen;
  logic [WORD_W-1:0] word_nxt;
  logic              complete;
  logic              at_wrap;
  logic              pending_q;
  logic              pending_d;
  logic              immediate;
  logic              commit;
  logic              dbg_wr;
  logic              val_en;
  logic [WORD_W-1:0] val_d;

  cpb_pair_track #(.HALF_W(HALF_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .clr      (ctl_wr),
    .freeze   (dbg_active),
    .seen     (seen),
    .word_nxt (word_nxt),
    .complete (complete)
  );

  cpb_wrap_detect #(.CNT_W(WORD_W)) u_wrap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt),
    .modulo  (modulo),
    .at_wrap (at_wrap)
  );

  always_comb begin
    immediate = !pwm_mode || (clk_sel == '0);
    commit    = (pending_q || complete) && (immediate || at_wrap);
    pending_d = (pending_q || complete) && !commit;
    dbg_wr    = dbg_active && wr_en;
    val_en    = commit || dbg_wr;
    val_d     = commit ? word_nxt : chan_val;
    if (dbg_wr) begin
      if (wr_hi) begin
        val_d[WORD_W-1:HALF_W] = wr_data;
      end else begin
        val_d[HALF_W-1:0] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      chan_val  <= '0;
    end else begin
      pending_q <= pending_d;
      if (val_en) begin
        chan_val <= val_d;
      end
    end
  end
endmodule

// File: rtl/chan_pair_buf_chk.sv
`timescale 1ns/1ps
module chan_pair_buf_chk
  import cpb_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned CS_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                wr_hi,
  input logic [HALF_W-1:0]   wr_data,
  input logic                ctl_wr,
  input logic                dbg_active,
  input logic [CS_W-1:0]     clk_sel,
  input logic                pwm_mode,
  input logic [2*HALF_W-1:0] chan_val,
  input seen_t               seen,
  input logic                commit,
  input logic                at_wrap
);
  // R7
  ctl_clears_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (seen == SEEN_NONE));

  // R8
  dbg_freezes_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && !ctl_wr) |=> $stable(seen));

  // R8
  dbg_hi_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && wr_en && wr_hi) |=> (chan_val[2*HALF_W-1:HALF_W] == $past(wr_data)));

  // R8
  dbg_lo_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && wr_en && !wr_hi) |=> (chan_val[HALF_W-1:0] == $past(wr_data)));

  // R3
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !(dbg_active && wr_en)) |=> $stable(chan_val));

  // R5
  pwm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && (clk_sel != '0) && !at_wrap && !(dbg_active && wr_en)) |=> $stable(chan_val));

  // R2
  pair_never_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(seen.hi && seen.lo));
endmodule

bind chan_pair_buf chan_pair_buf_chk #(.HALF_W(HALF_W), .CS_W(CS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_hi      (wr_hi),
  .wr_data    (wr_data),
  .ctl_wr     (ctl_wr),
  .dbg_active (dbg_active),
  .clk_sel    (clk_sel),
  .pwm_mode   (pwm_mode),
  .chan_val   (chan_val),
  .seen       (seen),
  .commit     (commit),
  .at_wrap    (at_wrap)
);

// File: tb/sim_chan_pair_buf.sv
`timescale 1ns/1ps
module sim_chan_pair_buf;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_hi;
  logic [7:0]  wr_data;
  logic        ctl_wr;
  logic        dbg_active;
  logic [15:0] cnt;
  logic [15:0] modulo;
  logic [1:0]  clk_sel;
  logic        pwm_mode;
  logic [15:0] chan_val;

  int checks;
  int errors;
  bit done;

  chan_pair_buf u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .ctl_wr(ctl_wr), .dbg_active(dbg_active), .cnt(cnt), .modulo(modulo),
    .clk_sel(clk_sel), .pwm_mode(pwm_mode), .chan_val(chan_val)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] exp);
    checks++;
    if (chan_val !== exp) begin
      errors++;
      $display("FAIL %s chan_val actual %h expected %h", req, chan_val, exp);
    end
  endtask

  task automatic wb(input logic hi, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cw();
    @(negedge clk);
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic set_dbg(input logic v);
    @(negedge clk);
    dbg_active = v;
  endtask

  task automatic step(input logic [15:0] v);
    @(negedge clk);
    cnt = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", 16'h0000);
    wb(1'b0, 8'h34);   // R1: one byte after reset must not complete a pair
    chk("R1", 16'h0000);
  endtask

  task automatic t_immediate();
    pwm_mode = 1'b0;
    wb(1'b1, 8'h12);
    chk("R2", 16'h1234);
    wb(1'b1, 8'hAB);
    chk("R3", 16'h1234);
    wb(1'b0, 8'hCD);
    chk("R2", 16'hABCD);
    wb(1'b1, 8'h11);
    wb(1'b1, 8'h22);
    chk("R3", 16'hABCD);
    wb(1'b0, 8'h33);
    chk("R3", 16'h2233);
  endtask

  task automatic t_clk_off();
    pwm_mode = 1'b1; clk_sel = 2'd0;
    wb(1'b0, 8'h55);
    wb(1'b1, 8'h66);
    chk("R4", 16'h6655);
  endtask

  task automatic t_pwm_wrap();
    pwm_mode = 1'b1; clk_sel = 2'd1; modulo = 16'h0010;
    step(16'h0005);
    wb(1'b1, 8'h77);
    wb(1'b0, 8'h88);
    chk("R5", 16'h6655);
    step(16'h000E);
    step(16'h000F);
    chk("R5", 16'h6655);
    step(16'h0010);
    chk("R5", 16'h7788);
  endtask

  task automatic t_free_run();
    modulo = 16'h0000;
    step(16'h0003);
    wb(1'b0, 8'h01);
    wb(1'b1, 8'h02);
    step(16'h000F);
    step(16'h0010);
    chk("R6", 16'h7788);
    step(16'hFFFD);
    step(16'hFFFE);
    chk("R6", 16'h7788);
    step(16'hFFFF);
    chk("R6", 16'h0201);
  endtask

  task automatic t_ctl_clear();
    pwm_mode = 1'b0;
    wb(1'b0, 8'hAA);
    cw();
    wb(1'b1, 8'hBB);
    chk("R7", 16'h0201);
    wb(1'b0, 8'hCC);
    chk("R7", 16'hBBCC);
    wb(1'b1, 8'hDD);
    set_dbg(1'b1);
    cw();
    set_dbg(1'b0);
    wb(1'b0, 8'hEE);
    chk("R7", 16'hBBCC);
    wb(1'b1, 8'hFF);
    chk("R7", 16'hFFEE);
  endtask

  task automatic t_debug();
    wb(1'b0, 8'h34);
    chk("R8", 16'hFFEE);
    set_dbg(1'b1);
    wb(1'b1, 8'hAB);
    chk("R8", 16'hABEE);
    wb(1'b0, 8'h99);
    chk("R8", 16'hAB99);
    set_dbg(1'b0);
    @(negedge clk);
    chk("R9", 16'hAB99);
    wb(1'b1, 8'h12);
    chk("R10", 16'h1234);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_hi = 1'b0; wr_data = '0; ctl_wr = 1'b0;
    dbg_active = 1'b0; cnt = '0; modulo = '0; clk_sel = 2'd0; pwm_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_clk_off();
    t_pwm_wrap();
    t_free_run();
    t_ctl_clear();
    t_debug();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule